// File: doc/BRIEF.md
# NOR Flash Command Sequencer with Completion Polling

This block turns a host request into the bus traffic that a parallel NOR flash needs for three operations: programming one word, erasing one sector and erasing the whole device. When a request is accepted, the block writes the unlock keys and the command codes on consecutive cycles through a simple write/read port. That port faces an external memory interface. The block then reads the target location again and again. It stops when the device's embedded algorithm shows the expected value, or when the device raises its failure flag (data bit 5) and a confirming read still does not match.

The host sees three outputs. `busy` is high for the whole operation. `done` is a one-cycle pulse. `pass` is valid in the same cycle as `done`. The read side of the memory port has variable latency: a one-cycle `mem_rd` strobe starts a read, and the data comes back with `mem_rvalid` any number of cycles later. Addresses are word addresses. Address bits 17 down to 12 select a sector of 4096 words.

Top module: `nor_cmd_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `mem_wr` and `mem_rd` are all low.
- R2: Request code 2'b00 programs a word. It makes four writes: 0x00AA to word 0x555, then 0x0055 to word 0x2AA, then 0x00A0 to word 0x555, then `req_data` to `req_addr`. The key offsets are taken from address zero.
- R3: Request code 2'b01 erases a sector. Let S be `req_addr` with bits 11:0 cleared. It makes six writes: 0x00AA to S+0x555, 0x0055 to S+0x2AA, 0x0080 to S+0x555, 0x00AA to S+0x555, 0x0055 to S+0x2AA, then 0x0030 to S.
- R4: Request code 2'b10 erases the chip. It makes the same first five writes as R3, relative to S, and then writes 0x0010 to S+0x555.
- R5: The writes go out on consecutive cycles, starting the cycle after the request is accepted. Each poll is a one-cycle `mem_rd` strobe at the poll address. That address is `req_addr` for a program and S for either erase. The first poll follows the last write on the next cycle, and each later poll follows the previous read data on the next cycle.
- R6: A read value equal to the expected value ends the operation with pass. The expected value is `req_data` for a program and 0xFFFF for an erase.
- R7: A read value that differs, with bit 5 clear, leads to another poll.
- R8: A read value that differs, with bit 5 set, leads to one more read. A match on that read means pass, and a mismatch means fail.
- R9: `done` is high for exactly one cycle: the cycle after the deciding read data returns. In that cycle `busy` is low and `pass` holds the result.
- R10: A request presented while `busy` is high is ignored.
- R11: Request code 2'b11 is ignored and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 reserved |
| req_addr | input | 18 | Target word address (program) or any address in the sector (erase) |
| req_data | input | 16 | Word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result, valid with done |
| mem_wr | output | 1 | Write strobe to the memory interface |
| mem_rd | output | 1 | Read strobe to the memory interface |
| mem_addr | output | 18 | Word address for the write or read |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |
| mem_rvalid | input | 1 | Read data valid |

## Verification
Take the edge that samples the request as edge 1. The memory model in the bench returns read data two cycles after each strobe. With N command writes (4 or 6) and R polls, `done` is therefore due right after edge N + 3R + 1. Each write appears on one of edges 2 to N+1, and each poll strobe appears one cycle after the previous read data. The bench counts falling edges from the request and checks that `done` arrives on exactly that count. It looks at `pass` and `busy` in that same half-cycle, and it checks that `done` is low one cycle later. Writes and read addresses are logged at rising edges and compared with sequences that the bench builds itself from R2 to R4.

// File: rtl/norseq_pkg.sv
package norseq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_SECT = 2'b01,
    OP_CHIP = 2'b10,
    OP_RSVD = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    VD_PASS,
    VD_FAIL,
    VD_REPOLL,
    VD_RECHECK
  } verdict_e;

  localparam logic [15:0] KEY_FIRST  = 16'h00AA;
  localparam logic [15:0] KEY_SECOND = 16'h0055;
  localparam logic [15:0] CODE_PROG  = 16'h00A0;
  localparam logic [15:0] CODE_ERASE = 16'h0080;
  localparam logic [15:0] CODE_CHIP  = 16'h0010;
  localparam logic [15:0] CODE_SECT  = 16'h0030;
  localparam logic [15:0] ERASED_WORD = 16'hFFFF;
  localparam logic [11:0] OFS_FIRST  = 12'h555;
  localparam logic [11:0] OFS_SECOND = 12'h2AA;
  localparam int unsigned FAIL_BIT   = 5;

  function automatic logic [2:0] seq_last(op_e op);
    return (op == OP_PROG) ? 3'd3 : 3'd5;
  endfunction

endpackage

// File: rtl/norseq_cmd_step.sv
module norseq_cmd_step
  import norseq_pkg::*;
#(
  parameter int AW = 18,
  parameter int DW = 16
) (
  input  op_e           op,
  input  logic [2:0]    step,
  input  logic [AW-1:0] sect_base,
  input  logic [AW-1:0] target,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          last
);
  logic [AW-1:0] key_base;
  logic [AW-1:0] at_first;
  logic [AW-1:0] at_second;

  always_comb begin
    key_base  = (op == OP_PROG) ? '0 : sect_base;
    at_first  = key_base + AW'(OFS_FIRST);
    at_second = key_base + AW'(OFS_SECOND);
    wr_addr   = at_first;
    wr_data   = DW'(KEY_FIRST);
    case (step)
      3'd0: begin wr_addr = at_first;  wr_data = DW'(KEY_FIRST);  end
      3'd1: begin wr_addr = at_second; wr_data = DW'(KEY_SECOND); end
      3'd2: begin
        wr_addr = at_first;
        wr_data = (op == OP_PROG) ? DW'(CODE_PROG) : DW'(CODE_ERASE);
      end
      3'd3: begin
        if (op == OP_PROG) begin
          wr_addr = target;
          wr_data = wdata;
        end else begin
          wr_addr = at_first;
          wr_data = DW'(KEY_FIRST);
        end
      end
      3'd4: begin wr_addr = at_second; wr_data = DW'(KEY_SECOND); end
      3'd5: begin
        if (op == OP_SECT) begin
          wr_addr = sect_base;
          wr_data = DW'(CODE_SECT);
        end else begin
          wr_addr = at_first;
          wr_data = DW'(CODE_CHIP);
        end
      end
      default: begin wr_addr = at_first; wr_data = DW'(KEY_FIRST); end
    endcase
    last = (step == seq_last(op));
  end
endmodule

// File: rtl/norseq_poll_judge.sv
module norseq_poll_judge
  import norseq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] rdata,
  input  logic [DW-1:0] expect_word,
  input  logic          second,
  output verdict_e      verdict
);
  always_comb begin
    if (rdata == expect_word)   verdict = VD_PASS;
    else if (second)            verdict = VD_FAIL;
    else if (rdata[FAIL_BIT])   verdict = VD_RECHECK;
    else                        verdict = VD_REPOLL;
  end
endmodule

// File: rtl/nor_cmd_sequencer.sv
module nor_cmd_sequencer
  import norseq_pkg::*;
#(
  parameter int AW      = 18,
  parameter int DW      = 16,
  parameter int SEC_LSB = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          mem_wr,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rvalid
);
  localparam int SECT_BITS = AW - SEC_LSB;

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD, S_WAIT} state_e;

  function automatic logic [AW-1:0] sector_of(logic [AW-1:0] a);
    return {a[AW-1:SEC_LSB], {SEC_LSB{1'b0}}};
  endfunction

  state_e        state_q;
  op_e           op_q;
  logic [2:0]    step_q;
  logic [AW-1:0] sect_q;
  logic [AW-1:0] tgt_q;
  logic [DW-1:0] data_q;
  logic [DW-1:0] exp_q;
  logic          second_q;
  logic          done_q;
  logic          pass_q;

  logic [AW-1:0] step_addr;
  logic [DW-1:0] step_data;
  logic          step_last;
  verdict_e      verdict;

  // Named internal events for the checker
  logic accept;
  logic ev_pass;
  logic ev_fail;
  logic ev_repoll;
  logic ev_recheck;

  op_e req_op_e;
  assign req_op_e = op_e'(req_op);

  norseq_cmd_step #(.AW(AW), .DW(DW)) u_step (
    .op        (op_q),
    .step      (step_q),
    .sect_base (sect_q),
    .target    (tgt_q),
    .wdata     (data_q),
    .wr_addr   (step_addr),
    .wr_data   (step_data),
    .last      (step_last)
  );

  norseq_poll_judge #(.DW(DW)) u_judge (
    .rdata       (mem_rdata),
    .expect_word (exp_q),
    .second      (second_q),
    .verdict     (verdict)
  );

  assign accept     = (state_q == S_IDLE) && req_valid && (req_op_e != OP_RSVD);
  assign ev_pass    = (state_q == S_WAIT) && mem_rvalid && (verdict == VD_PASS);
  assign ev_fail    = (state_q == S_WAIT) && mem_rvalid && (verdict == VD_FAIL);
  assign ev_repoll  = (state_q == S_WAIT) && mem_rvalid && (verdict == VD_REPOLL);
  assign ev_recheck = (state_q == S_WAIT) && mem_rvalid && (verdict == VD_RECHECK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      op_q     <= OP_PROG;
      step_q   <= '0;
      sect_q   <= '0;
      tgt_q    <= '0;
      data_q   <= '0;
      exp_q    <= '0;
      second_q <= 1'b0;
      done_q   <= 1'b0;
      pass_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (accept) begin
            op_q     <= req_op_e;
            step_q   <= '0;
            sect_q   <= sector_of(req_addr);
            tgt_q    <= (req_op_e == OP_PROG) ? req_addr : sector_of(req_addr);
            data_q   <= req_data;
            exp_q    <= (req_op_e == OP_PROG) ? req_data : DW'(ERASED_WORD);
            second_q <= 1'b0;
            state_q  <= S_WR;
          end
        end
        S_WR: begin
          if (step_last) state_q <= S_RD;
          else           step_q  <= step_q + 3'd1;
        end
        S_RD: state_q <= S_WAIT;
        S_WAIT: begin
          if (ev_pass || ev_fail) begin
            done_q  <= 1'b1;
            pass_q  <= ev_pass;
            state_q <= S_IDLE;
          end else if (ev_recheck) begin
            second_q <= 1'b1;
            state_q  <= S_RD;
          end else if (ev_repoll) begin
            state_q  <= S_RD;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign done      = done_q;
  assign pass      = pass_q;
  assign mem_wr    = (state_q == S_WR);
  assign mem_rd    = (state_q == S_RD);
  assign mem_addr  = (state_q == S_WR) ? step_addr : tgt_q;
  assign mem_wdata = (state_q == S_WR) ? step_data : '0;

  logic [SECT_BITS-1:0] unused_sect;
  assign unused_sect = sect_q[AW-1:SEC_LSB];
endmodule

// File: rtl/nor_cmd_sequencer_chk.sv
module nor_cmd_sequencer_chk #(
  parameter int AW = 18,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [1:0]    req_op,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic          mem_wr,
  input logic          mem_rd,
  input logic [DW-1:0] mem_wdata,
  input logic          ev_pass,
  input logic          ev_fail,
  input logic          ev_repoll,
  input logic          ev_recheck
);
  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r5_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && mem_rd));
  a_r5_strobes_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr || mem_rd) |-> busy);
  a_r10_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
  a_r2_first_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mem_wr && mem_wdata == DW'(16'h00AA)));
  a_r11_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_op == 2'b11) |=> !busy);
  a_r6_pass_reported: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pass |=> (done && pass));
  a_r8_fail_reported: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail |=> (done && !pass));
  a_r8_recheck_reads: assert property (@(posedge clk) disable iff (!rst_n)
    ev_recheck |=> mem_rd);
  a_r7_repoll_reads: assert property (@(posedge clk) disable iff (!rst_n)
    ev_repoll |=> mem_rd);
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!busy && !done && !mem_wr && !mem_rd));
endmodule

bind nor_cmd_sequencer nor_cmd_sequencer_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .busy       (busy),
  .done       (done),
  .pass       (pass),
  .mem_wr     (mem_wr),
  .mem_rd     (mem_rd),
  .mem_wdata  (mem_wdata),
  .ev_pass    (ev_pass),
  .ev_fail    (ev_fail),
  .ev_repoll  (ev_repoll),
  .ev_recheck (ev_recheck)
);

// File: tb/nor_cmd_sequencer_test.sv
module nor_cmd_sequencer_test;
  localparam int AW = 18;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          busy, done, pass, mem_wr, mem_rd;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          mem_rvalid;

  always #2 clk = ~clk;

  nor_cmd_sequencer #(.AW(AW), .DW(DW), .SEC_LSB(12)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
    .pass(pass), .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
  );

  int n_checks = 0;
  int n_fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [AW-1:0] wlog_a [0:255];
  logic [DW-1:0] wlog_d [0:255];
  int            wr_total = 0;
  int            rd_total = 0;
  int            rd_bad   = 0;
  int            rd_base  = 0;
  logic [AW-1:0] poll_addr = '0;
  logic [DW-1:0] script [0:3];
  logic          p1_v = 1'b0, p2_v = 1'b0;
  logic [DW-1:0] p1_d = '0, p2_d = '0;

  always @(posedge clk) begin
    p2_v <= p1_v;
    p2_d <= p1_d;
    p1_v <= 1'b0;
    if (mem_wr) begin
      wlog_a[wr_total % 256] <= mem_addr;
      wlog_d[wr_total % 256] <= mem_wdata;
      wr_total = wr_total + 1;
    end
    if (mem_rd) begin
      p1_v <= 1'b1;
      p1_d <= script[(rd_total - rd_base) > 3 ? 3 : (rd_total - rd_base)];
      if (mem_addr != poll_addr) rd_bad = rd_bad + 1;
      rd_total = rd_total + 1;
    end
  end
  assign mem_rvalid = p2_v;
  assign mem_rdata  = p2_d;

  // ---------------- expected sequence ----------------
  logic [AW-1:0] ew_a [0:5];
  logic [DW-1:0] ew_d [0:5];
  int            ew_n;

  task automatic build_expect(input logic [1:0] op, input logic [AW-1:0] a,
                              input logic [DW-1:0] d);
    logic [AW-1:0] s;
    logic [AW-1:0] k;
    s = a & ~18'h00FFF;
    k = (op == 2'b00) ? '0 : s;
    ew_a[0] = k | 18'h555; ew_d[0] = 16'h00AA;
    ew_a[1] = k | 18'h2AA; ew_d[1] = 16'h0055;
    if (op == 2'b00) begin
      ew_a[2] = 18'h555; ew_d[2] = 16'h00A0;
      ew_a[3] = a;       ew_d[3] = d;
      ew_n = 4;
      poll_addr = a;
    end else begin
      ew_a[2] = k | 18'h555; ew_d[2] = 16'h0080;
      ew_a[3] = k | 18'h555; ew_d[3] = 16'h00AA;
      ew_a[4] = k | 18'h2AA; ew_d[4] = 16'h0055;
      ew_a[5] = (op == 2'b01) ? s : (k | 18'h555);
      ew_d[5] = (op == 2'b01) ? 16'h0030 : 16'h0010;
      ew_n = 6;
      poll_addr = s;
    end
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [17:0] addr;
    logic [15:0] data;
    logic [2:0]  nrd;
    logic [15:0] r0, r1, r2, r3;
    logic        ok;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 18'h12345, 16'hBEEF, 3'd1, 16'hBEEF, 16'h0000, 16'h0000, 16'h0000, 1'b1},
    '{2'd0, 18'h00001, 16'h1234, 3'd3, 16'h0000, 16'h0010, 16'h1234, 16'h0000, 1'b1},
    '{2'd0, 18'h3FFFF, 16'h00FF, 3'd2, 16'h0020, 16'h00FF, 16'h0000, 16'h0000, 1'b1},
    '{2'd0, 18'h20000, 16'h5A5A, 3'd2, 16'h0020, 16'h0020, 16'h0000, 16'h0000, 1'b0},
    '{2'd1, 18'h2ABCD, 16'h0000, 3'd2, 16'h0000, 16'hFFFF, 16'h0000, 16'h0000, 1'b1},
    '{2'd2, 18'h00000, 16'h0000, 3'd2, 16'h0028, 16'h0008, 16'h0000, 16'h0000, 1'b0},
    '{2'd1, 18'h3FFFF, 16'h0000, 3'd2, 16'h0020, 16'hFFFF, 16'h0000, 16'h0000, 1'b1},
    '{2'd2, 18'h15000, 16'h0000, 3'd1, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 1'b1},
    '{2'd0, 18'h00555, 16'h0020, 3'd1, 16'h0020, 16'h0000, 16'h0000, 16'h0000, 1'b1},
    '{2'd1, 18'h01000, 16'h0000, 3'd4, 16'h0001, 16'h0002, 16'h0003, 16'hFFFF, 1'b1}
  };

  task automatic run_op(input vec_t v, input bit intrude, input string tag);
    int w0, r0, bad0, cyc, exp_cyc;
    string rq;
    rq = (v.op == 2'b00) ? "R2" : (v.op == 2'b01) ? "R3" : "R4";
    script[0] = v.r0; script[1] = v.r1; script[2] = v.r2; script[3] = v.r3;
    build_expect(v.op, v.addr, v.data);
    rd_base = rd_total;
    w0 = wr_total; r0 = rd_total; bad0 = rd_bad;
    @(negedge clk);
    req_valid = 1'b1; req_op = v.op; req_addr = v.addr; req_data = v.data;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (intrude && cyc >= 2 && cyc <= 4) begin
        req_valid = 1'b1; req_op = 2'b10; req_addr = 18'h3A123; req_data = 16'h1111;
      end else begin
        req_valid = 1'b0;
      end
    end while (!done && cyc < 300);
    exp_cyc = ew_n + 3 * int'(v.nrd) + 1;
    chk(cyc == exp_cyc, "R9", {tag, " done latency"}, cyc, exp_cyc);
    chk(!busy, "R9", {tag, " busy low with done"}, busy, 0);
    chk(pass == v.ok, v.ok ? "R6" : "R8", {tag, " pass"}, pass, v.ok);
    chk(wr_total - w0 == ew_n, rq, {tag, " write count"}, wr_total - w0, ew_n);
    for (int i = 0; i < 6; i++) begin
      if (i < ew_n) begin
        chk(wlog_a[(w0 + i) % 256] == ew_a[i], rq, {tag, " write addr"},
            wlog_a[(w0 + i) % 256], ew_a[i]);
        chk(wlog_d[(w0 + i) % 256] == ew_d[i], rq, {tag, " write data"},
            wlog_d[(w0 + i) % 256], ew_d[i]);
      end
    end
    chk(rd_total - r0 == int'(v.nrd), int'(v.nrd) > 1 ? "R7" : "R5",
        {tag, " poll count"}, rd_total - r0, v.nrd);
    chk(rd_bad == bad0, "R5", {tag, " poll address"}, rd_bad - bad0, 0);
    @(negedge clk);
    chk(!done, "R9", {tag, " done single cycle"}, done, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    int w0;
    script[0] = '0; script[1] = '0; script[2] = '0; script[3] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !pass && !mem_wr && !mem_rd, "R1", "outputs in reset",
        {busy, done, pass, mem_wr, mem_rd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_wr && !mem_rd, "R1", "outputs after reset",
        {busy, done, mem_wr, mem_rd}, 0);

    for (int i = 0; i < NV; i++) run_op(VECS[i], 1'b0, $sformatf("vec%0d", i));

    // R11: reserved op code starts nothing
    w0 = wr_total;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b11; req_addr = 18'h00123;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!busy, "R11", "reserved op busy", busy, 0);
    repeat (3) @(negedge clk);
    chk(!busy && wr_total == w0, "R11", "reserved op writes", wr_total - w0, 0);

    // R10: requests during busy ignored (writes and timing unchanged)
    run_op('{2'd0, 18'h0ABCD, 16'hC0DE, 3'd2, 16'h0000, 16'hC0DE, 16'h0000,
             16'h0000, 1'b1}, 1'b1, "R10 intrude");
    w0 = wr_total;
    repeat (4) @(negedge clk);
    chk(!busy && wr_total == w0, "R10", "no deferred start", wr_total - w0, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule